// File: doc/BRIEF.md
# Serial I/O Scan-Cycle Sequencer

This block drives a controller's repeating scan cycle over two serial chains: a chain of parallel-in/serial-out shift registers on the input side and a chain of serial-in/latched-output registers on the output side. Each scan runs four steps in a fixed order. It captures and reads in the input chain. It then opens a window for external user logic and waits for that logic to report completion. It then shifts the output bytes out to the output chain and latches them. It ends the scan with a watchdog kick and a status update.

Each chain holds 1 to 4 chips. The chip count of each chain is a runtime input, sampled once per scan. The block shows the captured input bytes as a bus that holds its value for a whole scan. It also keeps a 4-bit status word: a constant-zero bit, a constant-one bit, a flag that is set only during the first scan, and a bit that toggles on each scan. All serial clocks run at half the system clock rate.

Top module: `scan_io_seq`

## Requirements
- R1: After reset, `status_o` is 4'b0110: bit 0 = 0 (constant low), bit 1 = 1 (constant high), bit 2 = 1 (first-scan flag), bit 3 = 0 (scan toggle). At the same time `raw_o` is zero, `sin_ld_no` is high, and every other output is low.
- R2: After one idle cycle that follows reset, every scan runs these steps in order: load (1 cycle), input shift, user window, output shift, latch (1 cycle), kick (1 cycle). The next load follows the kick directly.
- R3: `sin_ld_no` is low for exactly one cycle per scan. It is followed by 8×N input clock periods. Each period is 2 cycles, low then high.
- R4: The bit read in the first input clock period goes to raw byte 0 bit 7. The first 8 bits fill raw byte 0, MSB first, and byte k holds the k-th chip nearest the data pin. Bytes at index N or above read as zero. `raw_o` changes only when the input shift ends.
- R5: `in_chips_i` and `out_chips_i` encode the chip count minus one (0 means 1 chip, 3 means 4 chips). Both are sampled in the load cycle and hold for that scan.
- R6: Output bytes are shifted in the order byte N-1 down to byte 0, each MSB first. `sout_data_o` changes only while `sout_clk_o` is low, so it is stable while the clock is high.
- R7: `out_bytes_i` is captured on the cycle where `user_done_i` is sampled high. Changing it later has no effect on that scan. `sout_latch_o` pulses for one cycle after the last output bit, once per scan.
- R8: `user_run_o` is high from the end of the input shift until the cycle in which `user_done_i` is sampled high. No serial clock toggles during that time.
- R9: `wdt_kick_o` pulses for one cycle right after the latch. On the following cycle the first-scan flag is 0 and the scan toggle bit has inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_chips_i | input | 2 | Input chip count minus one |
| out_chips_i | input | 2 | Output chip count minus one |
| sin_data_i | input | 1 | Serial data from the input chain |
| sin_ld_no | output | 1 | Input chain load (low) / shift (high) |
| sin_clk_o | output | 1 | Input chain shift clock |
| user_run_o | output | 1 | User logic window open |
| user_done_i | input | 1 | User logic finished |
| out_bytes_i | input | 32 | Output bytes, byte k at bits 8k+7..8k |
| sout_data_o | output | 1 | Serial data to the output chain |
| sout_clk_o | output | 1 | Output chain shift clock |
| sout_latch_o | output | 1 | Output chain latch strobe |
| wdt_kick_o | output | 1 | Per-scan watchdog kick |
| raw_o | output | 32 | Captured input bytes, byte k at bits 8k+7..8k |
| status_o | output | 4 | {toggle, first-scan, 1, 0} |

## Verification
The load, clock, latch and kick pins are decoded from the sequencer state, so each one changes one register after the edge that enters the step. `raw_o` changes at the edge that ends the last input clock period. The status bits change at the edge that leaves the kick cycle. A behavioural model in the bench advances on the same edges. The bench compares every output on the falling edge, half a cycle after each update.

The chain models in the bench act at the falling edge on the rising serial clocks they observe there. User completion is driven a chosen number of cycles into the window. This exercises the capture of the output bytes at exactly the done cycle.

// File: rtl/scan_io_pkg.sv
package scan_io_pkg;
  typedef enum logic [2:0] {
    ST_INIT, ST_LOAD, ST_SHIN, ST_USER, ST_SHOUT, ST_LATCH, ST_KICK
  } scan_st_e;

  function automatic int cnt_w(int chips);
    return (chips > 1) ? $clog2(chips) : 1;
  endfunction
endpackage

// File: rtl/scan_in_shift.sv
module scan_in_shift #(
  parameter int MAX_CHIPS = 4,
  parameter int CW = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clr_i,
  input  logic                   cap_i,
  input  logic                   commit_i,
  input  logic [CW+2:0]          idx_i,
  input  logic                   d_i,
  output logic [8*MAX_CHIPS-1:0] raw_o
);
  localparam int NB = 8 * MAX_CHIPS;
  logic [NB-1:0] stage_q, raw_q;
  logic [CW+2:0] pos;

  // byte from high index bits, MSB first within byte
  assign pos = {idx_i[CW+2:3], ~idx_i[2:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      raw_q   <= '0;
    end else begin
      if (clr_i)      stage_q      <= '0;
      else if (cap_i) stage_q[pos] <= d_i;
      if (commit_i)   raw_q        <= stage_q;
    end
  end

  assign raw_o = raw_q;
endmodule

// File: rtl/scan_out_shift.sv
module scan_out_shift #(
  parameter int MAX_CHIPS = 4,
  parameter int CW = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   load_i,
  input  logic [8*MAX_CHIPS-1:0] bytes_i,
  input  logic [CW-1:0]          last_i,
  input  logic [CW+2:0]          idx_i,
  input  logic                   en_i,
  output logic                   data_o
);
  localparam int NB = 8 * MAX_CHIPS;
  logic [NB-1:0] snap_q;
  logic [CW-1:0] byte_sel;
  logic [CW+2:0] pos;

  // farthest chip's byte goes first
  assign byte_sel = last_i - idx_i[CW+2:3];
  assign pos      = {byte_sel, ~idx_i[2:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     snap_q <= '0;
    else if (load_i) snap_q <= bytes_i;
  end

  assign data_o = en_i & snap_q[pos];
endmodule

// File: rtl/scan_status.sv
module scan_status (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       kick_i,
  output logic [3:0] status_o
);
  logic first_q, osc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q <= 1'b1;
      osc_q   <= 1'b0;
    end else if (kick_i) begin
      first_q <= 1'b0;
      osc_q   <= ~osc_q;
    end
  end

  assign status_o = {osc_q, first_q, 1'b1, 1'b0};
endmodule

// File: rtl/scan_io_seq.sv
module scan_io_seq #(
  parameter int MAX_CHIPS = 4,
  localparam int CW = scan_io_pkg::cnt_w(MAX_CHIPS),
  localparam int NB = 8 * MAX_CHIPS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] in_chips_i,
  input  logic [CW-1:0] out_chips_i,
  input  logic          sin_data_i,
  output logic          sin_ld_no,
  output logic          sin_clk_o,
  output logic          user_run_o,
  input  logic          user_done_i,
  input  logic [NB-1:0] out_bytes_i,
  output logic          sout_data_o,
  output logic          sout_clk_o,
  output logic          sout_latch_o,
  output logic          wdt_kick_o,
  output logic [NB-1:0] raw_o,
  output logic [3:0]    status_o
);
  import scan_io_pkg::*;

  scan_st_e      state_q;
  logic          phase_q;
  logic [CW+2:0] cnt_q;
  logic [CW-1:0] nin_q, nout_q;
  logic          in_last, out_last;

  assign in_last  = (cnt_q == {nin_q, 3'b111});
  assign out_last = (cnt_q == {nout_q, 3'b111});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_INIT;
      phase_q <= 1'b0;
      cnt_q   <= '0;
      nin_q   <= '0;
      nout_q  <= '0;
    end else begin
      case (state_q)
        ST_INIT: state_q <= ST_LOAD;
        ST_LOAD: begin
          nin_q   <= in_chips_i;
          nout_q  <= out_chips_i;
          cnt_q   <= '0;
          phase_q <= 1'b0;
          state_q <= ST_SHIN;
        end
        ST_SHIN: begin
          phase_q <= ~phase_q;
          if (phase_q) begin
            if (in_last) state_q <= ST_USER;
            else         cnt_q   <= cnt_q + 1'b1;
          end
        end
        ST_USER: begin
          if (user_done_i) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
            state_q <= ST_SHOUT;
          end
        end
        ST_SHOUT: begin
          phase_q <= ~phase_q;
          if (phase_q) begin
            if (out_last) state_q <= ST_LATCH;
            else          cnt_q   <= cnt_q + 1'b1;
          end
        end
        ST_LATCH: state_q <= ST_KICK;
        ST_KICK:  state_q <= ST_LOAD;
        default:  state_q <= ST_INIT;
      endcase
    end
  end

  assign sin_ld_no    = (state_q != ST_LOAD);
  assign sin_clk_o    = (state_q == ST_SHIN) && phase_q;
  assign user_run_o   = (state_q == ST_USER);
  assign sout_clk_o   = (state_q == ST_SHOUT) && phase_q;
  assign sout_latch_o = (state_q == ST_LATCH);
  assign wdt_kick_o   = (state_q == ST_KICK);

  scan_in_shift #(.MAX_CHIPS(MAX_CHIPS), .CW(CW)) in_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (state_q == ST_LOAD),
    .cap_i    ((state_q == ST_SHIN) && !phase_q),
    .commit_i ((state_q == ST_SHIN) && phase_q && in_last),
    .idx_i    (cnt_q),
    .d_i      (sin_data_i),
    .raw_o    (raw_o)
  );

  scan_out_shift #(.MAX_CHIPS(MAX_CHIPS), .CW(CW)) out_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  ((state_q == ST_USER) && user_done_i),
    .bytes_i (out_bytes_i),
    .last_i  (nout_q),
    .idx_i   (cnt_q),
    .en_i    (state_q == ST_SHOUT),
    .data_o  (sout_data_o)
  );

  scan_status stat_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .kick_i   (state_q == ST_KICK),
    .status_o (status_o)
  );
endmodule

// File: rtl/scan_io_seq_chk.sv
module scan_io_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sin_ld_no,
  input logic       sin_clk_o,
  input logic       user_run_o,
  input logic       sout_data_o,
  input logic       sout_clk_o,
  input logic       sout_latch_o,
  input logic       wdt_kick_o,
  input logic [3:0] status_o
);
  // R3
  ld_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sin_ld_no |=> sin_ld_no);
  // R8
  user_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    user_run_o |-> (!sin_clk_o && !sout_clk_o));
  // R6
  sout_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sout_clk_o |-> $stable(sout_data_o));
  // R7
  latch_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sout_latch_o |=> (!sout_latch_o && wdt_kick_o));
  // R9
  osc_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_kick_o |=> ((status_o[3] != $past(status_o[3])) && !status_o[2]));
  // R2
  load_after_kick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_kick_o |=> !sin_ld_no);
endmodule

bind scan_io_seq scan_io_seq_chk chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sin_ld_no    (sin_ld_no),
  .sin_clk_o    (sin_clk_o),
  .user_run_o   (user_run_o),
  .sout_data_o  (sout_data_o),
  .sout_clk_o   (sout_clk_o),
  .sout_latch_o (sout_latch_o),
  .wdt_kick_o   (wdt_kick_o),
  .status_o     (status_o)
);

// File: tb/scan_io_seq_tb.sv
`timescale 1ns/1ps
module scan_io_seq_tb_top;
  localparam int NSCANS = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  in_chips_i = '0, out_chips_i = '0;
  logic        sin_data_i = 1'b0;
  logic        user_done_i = 1'b0;
  logic [31:0] out_bytes_i = '0;
  logic        sin_ld_no, sin_clk_o, user_run_o, sout_data_o, sout_clk_o;
  logic        sout_latch_o, wdt_kick_o;
  logic [31:0] raw_o;
  logic [3:0]  status_o;

  always #2.5 clk_i = ~clk_i;

  scan_io_seq dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_chips_i(in_chips_i), .out_chips_i(out_chips_i),
    .sin_data_i(sin_data_i), .sin_ld_no(sin_ld_no), .sin_clk_o(sin_clk_o),
    .user_run_o(user_run_o), .user_done_i(user_done_i), .out_bytes_i(out_bytes_i),
    .sout_data_o(sout_data_o), .sout_clk_o(sout_clk_o), .sout_latch_o(sout_latch_o),
    .wdt_kick_o(wdt_kick_o), .raw_o(raw_o), .status_o(status_o)
  );

  int n_chk = 0, n_err = 0;
  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // scan configuration
  logic [31:0] par_r = '0;
  int          cur_lat = 0;
  task automatic set_cfg(int i);
    case (i % 6)
      0: begin in_chips_i = 2'd0; out_chips_i = 2'd0; cur_lat = 0; end
      1: begin in_chips_i = 2'd3; out_chips_i = 2'd3; cur_lat = 2; end
      2: begin in_chips_i = 2'd1; out_chips_i = 2'd2; cur_lat = 5; end
      3: begin in_chips_i = 2'd2; out_chips_i = 2'd0; cur_lat = 1; end
      4: begin in_chips_i = 2'd0; out_chips_i = 2'd3; cur_lat = 0; end
      default: begin in_chips_i = 2'd3; out_chips_i = 2'd1; cur_lat = 3; end
    endcase
    par_r       = 32'hA5C3_1E78 ^ (32'h9E37_79B9 * (i + 1));
    out_bytes_i = 32'h5B2D_90F1 ^ (32'h7F4A_7C15 * (i + 3));
  endtask

  // behavioural scan model: seg 0 idle,1 load,2 in,3 user,4 out,5 latch,6 kick
  int          m_seg = 0, m_k = 0, m_nin = 1, m_nout = 1, m_scans = 0;
  logic [31:0] m_par = '0, m_raw = '0, m_q = '0;
  logic        m_first = 1'b1, m_osc = 1'b0;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_seg = 0; m_k = 0; m_raw = '0; m_first = 1'b1; m_osc = 1'b0;
    end else begin
      case (m_seg)
        0: m_seg = 1;
        1: begin
          m_nin = int'(in_chips_i) + 1; m_nout = int'(out_chips_i) + 1;
          m_par = par_r; m_seg = 2; m_k = 0;
        end
        2: if (m_k == 16*m_nin - 1) begin
             m_raw = '0;
             for (int b = 0; b < m_nin; b++) m_raw[8*b +: 8] = m_par[8*b +: 8];
             m_seg = 3; m_k = 0;
           end else m_k++;
        3: if (user_done_i) begin m_q = out_bytes_i; m_seg = 4; m_k = 0; end
           else m_k++;
        4: if (m_k == 16*m_nout - 1) m_seg = 5; else m_k++;
        5: m_seg = 6;
        default: begin m_first = 1'b0; m_osc = ~m_osc; m_seg = 1; m_scans++; end
      endcase
    end
  end

  // external chain models
  logic [31:0] ivec = '0, osr = '0, olat = '0;
  logic        prev_i = 1'b0, prev_o = 1'b0;
  int          rise_cnt = 0;

  task automatic step();
    logic [31:0] e_raw;
    int b, byt;
    logic e_d;
    if (!sin_ld_no) begin
      ivec = {par_r[7:0], par_r[15:8], par_r[23:16], par_r[31:24]};
      rise_cnt = 0;
    end else if (sin_clk_o && !prev_i) begin
      ivec = ivec << 1; rise_cnt++;
    end
    prev_i = sin_clk_o;
    if (sout_clk_o && !prev_o) osr = {osr[30:0], sout_data_o};
    prev_o = sout_clk_o;
    if (sout_latch_o) olat = osr;
    sin_data_i = ivec[31];

    chk("R2", "step code", {26'd0, !sin_ld_no, sin_clk_o | sout_clk_o, user_run_o,
        sout_latch_o, wdt_kick_o, 1'b0},
        {26'd0, m_seg == 1, (m_seg == 2 || m_seg == 4) && (m_k % 2 == 1), m_seg == 3,
         m_seg == 5, m_seg == 6, 1'b0});
    chk("R3", "sin_ld_no", 32'(sin_ld_no), 32'(m_seg != 1));
    chk("R3", "sin_clk_o", 32'(sin_clk_o), 32'(m_seg == 2 && m_k % 2 == 1));
    chk("R8", "user_run_o", 32'(user_run_o), 32'(m_seg == 3));
    chk("R6", "sout_clk_o", 32'(sout_clk_o), 32'(m_seg == 4 && m_k % 2 == 1));
    e_d = 1'b0;
    if (m_seg == 4) begin
      b = m_k / 2; byt = m_nout - 1 - b / 8;
      e_d = m_q[byt*8 + 7 - b % 8];
    end
    chk("R6", "sout_data_o", 32'(sout_data_o), 32'(e_d));
    chk("R7", "sout_latch_o", 32'(sout_latch_o), 32'(m_seg == 5));
    chk("R9", "wdt_kick_o", 32'(wdt_kick_o), 32'(m_seg == 6));
    chk(rst_ni ? "R9" : "R1", "status_o", 32'(status_o), {28'd0, m_osc, m_first, 2'b10});
    e_raw = m_raw;
    chk("R4", "raw_o", raw_o, e_raw);
    if (!rst_ni) chk("R1", "idle outputs",
        {26'd0, sin_ld_no, sin_clk_o, user_run_o, sout_clk_o, sout_latch_o, wdt_kick_o},
        32'h20);
    if (m_seg == 6) begin
      logic [31:0] mask;
      mask = (m_nout == 4) ? 32'hFFFF_FFFF : ((32'd1 << (8*m_nout)) - 1);
      chk("R7", "latched outputs", olat & mask, m_q & mask);
      chk("R5", "input clock count", 32'(rise_cnt), 32'(8*m_nin));
      set_cfg(m_scans + 1);
    end
    user_done_i = (m_seg == 3 && m_k == cur_lat);
    if (m_seg == 4 && m_k == 3) out_bytes_i = ~out_bytes_i;  // R7: after capture
  endtask

  initial begin
    int cyc;
    cyc = 0;
    set_cfg(0);
    repeat (3) begin @(negedge clk_i); step(); end
    rst_ni = 1'b1;
    while (m_scans < NSCANS) begin
      @(negedge clk_i);
      step();
      cyc++;
      if (cyc > 20000) begin
        n_chk++; n_err++;
        $display("FAIL R2 watchdog: actual %0d cycles expected < 20000", cyc);
        break;
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule